// File: doc/BRIEF.md
# Programmable Parallel Expansion Bus Controller

This block converts single read or write requests from an internal host port into timed strobe cycles on an external asynchronous parallel bus. The bus is shared by up to eight regions, each reached through its own active-low chip select. Every region has a static configuration word. The word sets how far each bus phase is stretched, whether the region carries 8 or 16 data bits, whether writes are permitted, whether the address is first placed on the data pins, and whether single-byte reads are allowed on a 16-bit region.

An accepted request walks through five phases in a fixed order: address, setup, strobe, hold and recovery. Each phase lasts one base cycle plus its per-region extension. Chip select covers setup through hold, and the read or write strobe covers only the strobe phase. Read data is captured on the final strobe cycle. A one-cycle done pulse marks the end of recovery. A request the region cannot serve is answered with a one-cycle error pulse and never reaches the pins.

Top module: `exbus_ctrl`

## Requirements
- R1: After reset, all chip selects and both strobes are high, the data pins are not driven, and busy, done and error are low.
- R2: The region word for chip select n sits at bits [n*18 +: 18] of `cfg_words`. Its fields are: address extension [1:0], setup extension [3:2], strobe extension [7:4], hold extension [9:8], recovery extension [13:10], 8-bit-only [14], write permit [15], address/data multiplex [16] and byte read allowed [17]. Only the chip select of the requested region ever goes low, and never more than one at a time.
- R3: The phases run in the order address, setup, strobe, hold, recovery, and each lasts 1 + its extension cycles. With the accept edge as cycle 0, chip select goes low in cycle 1+A, stays low for 3+S+T+H cycles, and the strobe is low for 1+T cycles starting in cycle 2+A+S.
- R4: `rsp_done` is high for exactly one cycle, in cycle 5+A+S+T+H+R. In that cycle `busy` is low and the bus is quiet.
- R5: A permitted write pulses `bus_wr_n` and never `bus_rd_n`. Write data is driven with the output enable from setup through hold and stays stable while the strobe is low.
- R6: A write to a region whose write permit is 0 gives `rsp_err` for one cycle in cycle 0. It gives no chip select, no strobe and no done.
- R7: On an 8-bit-only region, writes drive zero on data bits [15:8], and reads return the low data byte zero-extended.
- R8: A read on a 16-bit region returns all 16 bits. A byte read (`req_byte`=1) there with byte read allowed returns byte lane addr[0] (0: bits [7:0], 1: bits [15:8]) zero-extended. With byte read not allowed, it is rejected as in R6.
- R9: With multiplex set, the data pins carry the low address bits with the output enable on during the address phase. On reads, the output enable is off during the strobe phase.
- R10: Read data is the value on `bus_data_i` during the last strobe cycle.
- R11: A request presented while an access is in progress is ignored.
- R12: `req_byte` has no effect on writes: a 16-bit region writes all 16 bits even when byte read is not allowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_words | input | NUM_CS*18 | Per-region configuration words |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_byte | input | 1 | Single-byte read request |
| req_cs | input | CS_W | Target region |
| req_addr | input | ADDR_W | Address within the region |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Access in progress |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | One-cycle rejection pulse |
| rsp_rdata | output | 16 | Read data, valid with done |
| bus_cs_n | output | NUM_CS | Active-low chip selects |
| bus_addr | output | ADDR_W | Bus address |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_data_o | output | 16 | Data pins, outgoing |
| bus_data_oe | output | 1 | Data pin output enable |
| bus_data_i | input | 16 | Data pins, incoming |

## Verification
The checker watches, on every cycle, that at most one chip select is active and that the two strobes never overlap. It also checks that a strobe is always preceded by chip select, that write data holds steady under the write strobe, and that done and error are exclusive and come only on a quiet bus. The exact phase lengths, latency, byte-lane selection, the last-cycle sampling point and the ignoring of requests during an access depend on the configuration words. Only the bench's sweeps over many settings can show these, as it counts pin cycles against the arithmetic of R3 and R4.

// File: rtl/exbus_pkg.sv
package exbus_pkg;
  localparam int DATA_W = 16;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic [3:0] t_rec;
    logic [1:0] t_hold;
    logic [3:0] t_strb;
    logic [1:0] t_setup;
    logic [1:0] t_addr;
  } cs_timing_t;

  typedef struct packed {
    logic       byte_rd_ok;
    logic       mux_ad;
    logic       wr_en;
    logic       narrow;
    cs_timing_t tim;
  } cs_cfg_t;

  localparam int CFG_W = $bits(cs_cfg_t);

  typedef enum logic [2:0] {
    PH_IDLE, PH_ADDR, PH_SETUP, PH_STROBE, PH_HOLD, PH_RECOV
  } phase_e;
endpackage

// File: rtl/exbus_cfg_sel.sv
module exbus_cfg_sel
  import exbus_pkg::*;
#(
  parameter int NUM_CS = 8,
  localparam int CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic [NUM_CS*CFG_W-1:0] cfg_words,
  input  logic [CS_W-1:0]         sel,
  output cs_cfg_t                 cfg
);
  cs_cfg_t table_q [NUM_CS];

  for (genvar g = 0; g < NUM_CS; g++) begin : g_unpack
    assign table_q[g] = cs_cfg_t'(cfg_words[g*CFG_W +: CFG_W]);
  end

  always_comb begin
    cfg = '0;
    for (int i = 0; i < NUM_CS; i++)
      if (sel == CS_W'(i)) cfg = table_q[i];
  end
endmodule

// File: rtl/exbus_phase_seq.sv
module exbus_phase_seq
  import exbus_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  cs_timing_t tim,
  output phase_e     ph,
  output phase_e     ph_nxt,
  output logic       last_strobe,
  output logic       finish
);
  logic [3:0] cnt_q, cnt_nxt;

  function automatic logic [3:0] ext_len(phase_e p, cs_timing_t t);
    case (p)
      PH_ADDR:   return {2'b00, t.t_addr};
      PH_SETUP:  return {2'b00, t.t_setup};
      PH_STROBE: return t.t_strb;
      PH_HOLD:   return {2'b00, t.t_hold};
      PH_RECOV:  return t.t_rec;
      default:   return 4'd0;
    endcase
  endfunction

  function automatic phase_e succ(phase_e p);
    case (p)
      PH_ADDR:   return PH_SETUP;
      PH_SETUP:  return PH_STROBE;
      PH_STROBE: return PH_HOLD;
      PH_HOLD:   return PH_RECOV;
      default:   return PH_IDLE;
    endcase
  endfunction

  always_comb begin
    ph_nxt      = ph;
    cnt_nxt     = cnt_q;
    finish      = 1'b0;
    last_strobe = (ph == PH_STROBE) && (cnt_q == 4'd0);
    if (ph == PH_IDLE) begin
      if (start) begin
        ph_nxt  = PH_ADDR;
        cnt_nxt = ext_len(PH_ADDR, tim);
      end
    end else if (cnt_q == 4'd0) begin
      ph_nxt  = succ(ph);
      cnt_nxt = ext_len(succ(ph), tim);
      finish  = (ph == PH_RECOV);
    end else begin
      cnt_nxt = cnt_q - 4'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph    <= PH_IDLE;
      cnt_q <= 4'd0;
    end else begin
      ph    <= ph_nxt;
      cnt_q <= cnt_nxt;
    end
  end
endmodule

// File: rtl/exbus_pin_drv.sv
module exbus_pin_drv
  import exbus_pkg::*;
#(
  parameter int NUM_CS = 8,
  parameter int ADDR_W = 16,
  localparam int CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  phase_e            ph_nxt,
  input  logic [CS_W-1:0]   cs_nxt,
  input  logic              wr_nxt,
  input  logic              mux_nxt,
  input  logic              narrow_nxt,
  input  logic [ADDR_W-1:0] addr_nxt,
  input  logic [DATA_W-1:0] wdata_nxt,
  output logic              busy,
  output logic [NUM_CS-1:0] bus_cs_n,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_rd_n,
  output logic              bus_wr_n,
  output logic [DATA_W-1:0] bus_data_o,
  output logic              bus_data_oe
);
  logic [DATA_W-1:0] addr_on_data;
  logic [DATA_W-1:0] wdata_lane;
  logic              cs_window;

  if (ADDR_W >= DATA_W) begin : g_addr_trunc
    assign addr_on_data = addr_nxt[DATA_W-1:0];
  end else begin : g_addr_ext
    assign addr_on_data = {{(DATA_W-ADDR_W){1'b0}}, addr_nxt};
  end

  assign wdata_lane = narrow_nxt ? {{(DATA_W-BYTE_W){1'b0}}, wdata_nxt[BYTE_W-1:0]}
                                 : wdata_nxt;
  assign cs_window  = (ph_nxt == PH_SETUP) || (ph_nxt == PH_STROBE) || (ph_nxt == PH_HOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy        <= 1'b0;
      bus_cs_n    <= '1;
      bus_addr    <= '0;
      bus_rd_n    <= 1'b1;
      bus_wr_n    <= 1'b1;
      bus_data_o  <= '0;
      bus_data_oe <= 1'b0;
    end else begin
      busy     <= (ph_nxt != PH_IDLE);
      bus_cs_n <= '1;
      if (cs_window) bus_cs_n[cs_nxt] <= 1'b0;
      bus_rd_n <= !((ph_nxt == PH_STROBE) && !wr_nxt);
      bus_wr_n <= !((ph_nxt == PH_STROBE) && wr_nxt);
      bus_addr <= (ph_nxt != PH_IDLE) ? addr_nxt : '0;
      if ((ph_nxt == PH_ADDR) && mux_nxt) begin
        bus_data_o  <= addr_on_data;
        bus_data_oe <= 1'b1;
      end else if (cs_window && wr_nxt) begin
        bus_data_o  <= wdata_lane;
        bus_data_oe <= 1'b1;
      end else begin
        bus_data_o  <= '0;
        bus_data_oe <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/exbus_ctrl.sv
module exbus_ctrl
  import exbus_pkg::*;
#(
  parameter int NUM_CS = 8,
  parameter int ADDR_W = 16,
  localparam int CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_CS*CFG_W-1:0] cfg_words,
  input  logic                    req_valid,
  input  logic                    req_write,
  input  logic                    req_byte,
  input  logic [CS_W-1:0]         req_cs,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [DATA_W-1:0]       req_wdata,
  output logic                    busy,
  output logic                    rsp_done,
  output logic                    rsp_err,
  output logic [DATA_W-1:0]       rsp_rdata,
  output logic [NUM_CS-1:0]       bus_cs_n,
  output logic [ADDR_W-1:0]       bus_addr,
  output logic                    bus_rd_n,
  output logic                    bus_wr_n,
  output logic [DATA_W-1:0]       bus_data_o,
  output logic                    bus_data_oe,
  input  logic [DATA_W-1:0]       bus_data_i
);
  cs_cfg_t           cfg_live, cfg_q, cfg_use;
  phase_e            ph, ph_nxt;
  logic              accept, ok, start, reject, last_strobe, finish;
  logic [CS_W-1:0]   cs_q;
  logic              wr_q, byte_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rd_fmt;

  exbus_cfg_sel #(.NUM_CS(NUM_CS)) i_cfg_sel (
    .cfg_words(cfg_words), .sel(req_cs), .cfg(cfg_live)
  );

  assign accept  = req_valid && (ph == PH_IDLE);
  assign ok      = !(req_write && !cfg_live.wr_en) &&
                   !(!req_write && req_byte && !cfg_live.narrow && !cfg_live.byte_rd_ok);
  assign start   = accept && ok;
  assign reject  = accept && !ok;
  assign cfg_use = (ph == PH_IDLE) ? cfg_live : cfg_q;

  exbus_phase_seq i_seq (
    .clk(clk), .rst(rst), .start(start), .tim(cfg_use.tim),
    .ph(ph), .ph_nxt(ph_nxt), .last_strobe(last_strobe), .finish(finish)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q   <= '0;
      cs_q    <= '0;
      wr_q    <= 1'b0;
      byte_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      cfg_q   <= cfg_live;
      cs_q    <= req_cs;
      wr_q    <= req_write;
      byte_q  <= req_byte;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  exbus_pin_drv #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W)) i_pins (
    .clk(clk), .rst(rst), .ph_nxt(ph_nxt),
    .cs_nxt    (start ? req_cs           : cs_q),
    .wr_nxt    (start ? req_write        : wr_q),
    .mux_nxt   (start ? cfg_live.mux_ad  : cfg_q.mux_ad),
    .narrow_nxt(start ? cfg_live.narrow  : cfg_q.narrow),
    .addr_nxt  (start ? req_addr         : addr_q),
    .wdata_nxt (start ? req_wdata        : wdata_q),
    .busy(busy), .bus_cs_n(bus_cs_n), .bus_addr(bus_addr),
    .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
    .bus_data_o(bus_data_o), .bus_data_oe(bus_data_oe)
  );

  always_comb begin
    if (cfg_q.narrow)
      rd_fmt = {{(DATA_W-BYTE_W){1'b0}}, bus_data_i[BYTE_W-1:0]};
    else if (byte_q)
      rd_fmt = {{(DATA_W-BYTE_W){1'b0}},
                addr_q[0] ? bus_data_i[DATA_W-1:BYTE_W] : bus_data_i[BYTE_W-1:0]};
    else
      rd_fmt = bus_data_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_done  <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_done <= finish;
      rsp_err  <= reject;
      if (last_strobe && !wr_q) rsp_rdata <= rd_fmt;
    end
  end
endmodule

// File: rtl/exbus_ctrl_chk.sv
module exbus_ctrl_chk #(
  parameter int NUM_CS = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              rsp_done,
  input logic              rsp_err,
  input logic [NUM_CS-1:0] bus_cs_n,
  input logic              bus_rd_n,
  input logic              bus_wr_n,
  input logic [15:0]       bus_data_o,
  input logic              bus_data_oe
);
  AST_ONE_CS: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~bus_cs_n)); // R2
  AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (rst)
    !(!bus_rd_n && !bus_wr_n)); // R3
  AST_CS_BEFORE_STROBE: assert property (@(posedge clk) disable iff (rst)
    ($fell(bus_rd_n) || $fell(bus_wr_n)) |-> !(&$past(bus_cs_n))); // R3
  AST_STROBE_UNDER_CS: assert property (@(posedge clk) disable iff (rst)
    (!bus_rd_n || !bus_wr_n) |-> !(&bus_cs_n)); // R3
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
    rsp_done |-> (&bus_cs_n && bus_rd_n && bus_wr_n && !busy)); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done); // R4
  AST_WDATA_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!bus_wr_n && $past(!bus_wr_n)) |-> ($stable(bus_data_o) && bus_data_oe)); // R5
  AST_ERR_NO_BUS: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> (&bus_cs_n && bus_rd_n && bus_wr_n && !rsp_done)); // R6
  AST_READ_RELEASED: assert property (@(posedge clk) disable iff (rst)
    !bus_rd_n |-> !bus_data_oe); // R9
endmodule

bind exbus_ctrl exbus_ctrl_chk #(.NUM_CS(NUM_CS)) i_chk (
  .clk(clk), .rst(rst), .busy(busy), .rsp_done(rsp_done), .rsp_err(rsp_err),
  .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
  .bus_data_o(bus_data_o), .bus_data_oe(bus_data_oe)
);

// File: tb/test_exbus_ctrl.sv
module test_exbus_ctrl;
  localparam int NCS = 8;
  localparam int CW  = 18;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NCS*CW-1:0] cfg_words = '0;
  logic          req_valid = 1'b0, req_write = 1'b0, req_byte = 1'b0;
  logic [2:0]    req_cs = '0;
  logic [15:0]   req_addr = '0, req_wdata = '0;
  logic          busy, rsp_done, rsp_err, bus_rd_n, bus_wr_n, bus_data_oe;
  logic [15:0]   rsp_rdata, bus_addr, bus_data_o, bus_data_i;
  logic [NCS-1:0] bus_cs_n;
  logic [15:0]   rdcnt = '0;

  int checks = 0, failures = 0;
  bit finished = 0;
  int t1 [NCS], t2 [NCS], t3 [NCS], t4 [NCS], t5 [NCS];
  bit nar [NCS], we [NCS], mux [NCS], bro [NCS];

  always #2 clk = ~clk;

  exbus_ctrl i_exbus_ctrl (
    .clk(clk), .rst(rst), .cfg_words(cfg_words), .req_valid(req_valid),
    .req_write(req_write), .req_byte(req_byte), .req_cs(req_cs),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy),
    .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .bus_cs_n(bus_cs_n), .bus_addr(bus_addr), .bus_rd_n(bus_rd_n),
    .bus_wr_n(bus_wr_n), .bus_data_o(bus_data_o), .bus_data_oe(bus_data_oe),
    .bus_data_i(bus_data_i)
  );

  // device model: value depends on address and on strobe cycles elapsed
  always @(posedge clk) rdcnt <= bus_rd_n ? 16'd0 : rdcnt + 16'd1;
  assign bus_data_i = (bus_addr ^ 16'h5A3C) + rdcnt;

  task automatic chk(input bit cond, input string req, input int act, input int exp);
    checks++;
    if (!cond) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load_cfg(input int p);
    for (int c = 0; c < NCS; c++) begin
      t1[c] = (p + c) % 4;        t2[c] = (p * 3 + c) % 4;
      t3[c] = (p * 5 + c * 3) % 16; t4[c] = (p + 2 * c) % 4;
      t5[c] = (p * 7 + c) % 16;
      if (p == 0) begin t1[c] = 0; t2[c] = 0; t3[c] = 0; t4[c] = 0; t5[c] = 0; end
      if (p == 11) begin t1[c] = 3; t2[c] = 3; t3[c] = 15; t4[c] = 3; t5[c] = 15; end
      nar[c] = ((p + c) % 3) == 0;
      we[c]  = (((p >> 1) + c) % 4) != 0;
      mux[c] = ((p + c) % 2) == 1;
      bro[c] = (((p / 2) + c) % 2) == 1;
      cfg_words[c*CW +: CW] = {bro[c], mux[c], we[c], nar[c], 4'(t5[c]), 2'(t4[c]),
                               4'(t3[c]), 2'(t2[c]), 2'(t1[c])};
    end
  endtask

  task automatic access(input int cs, input bit wr, input bit byt,
                        input logic [15:0] a, input logic [15:0] wd, input bit poke);
    bit exp_err = (wr && !we[cs]) || (!wr && byt && !nar[cs] && !bro[cs]);
    int n = 5 + t1[cs] + t2[cs] + t3[cs] + t4[cs] + t5[cs];
    int cs_cnt = 0, cs_first = -1, st_cnt = 0, st_first = -1, i = 0;
    int wrong_st = 0, other_cs = 0, mux_bad = 0, wd_bad = 0, oe_bad = 0;
    logic [15:0] raw, exp_rd, exp_wd;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_byte = byt; req_cs = 3'(cs);
    req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    if (exp_err) begin
      chk(rsp_err === 1'b1, wr ? "R6 write refused" : "R8 byte read refused", rsp_err, 1);
      chk(&bus_cs_n && bus_rd_n && bus_wr_n && !rsp_done && !busy,
          "R6 no bus cycle on reject", bus_cs_n, 8'hFF);
      @(negedge clk);
      chk(!rsp_err && !busy && &bus_cs_n, "R6 error is one pulse", rsp_err, 0);
      return;
    end
    exp_wd = nar[cs] ? {8'h00, wd[7:0]} : wd;
    while (rsp_done !== 1'b1 && i < 100) begin
      if (poke && i == 2) begin
        req_valid = 1'b1; req_cs = 3'(cs ^ 1); req_write = 1'b0; req_byte = 1'b0;
      end else req_valid = 1'b0;
      if (bus_cs_n[cs] == 1'b0) begin cs_cnt++; if (cs_first < 0) cs_first = i; end
      if ((bus_cs_n | (8'd1 << cs)) != 8'hFF) other_cs++;
      if (!(wr ? bus_wr_n : bus_rd_n)) begin st_cnt++; if (st_first < 0) st_first = i; end
      if (!(wr ? bus_rd_n : bus_wr_n)) wrong_st++;
      if (mux[cs] && i <= t1[cs] && !(bus_data_oe && bus_data_o == a)) mux_bad++;
      if (wr && !bus_wr_n && !(bus_data_oe && bus_data_o == exp_wd)) wd_bad++;
      if (!wr && !bus_rd_n && bus_data_oe) oe_bad++;
      @(negedge clk);
      i++;
    end
    req_valid = 1'b0;
    chk(i == n, "R4 done latency", i, n);
    chk(!busy && &bus_cs_n, "R4 idle in done cycle", busy, 0);
    chk(cs_first == 1 + t1[cs], "R3 chip select start", cs_first, 1 + t1[cs]);
    chk(cs_cnt == 3 + t2[cs] + t3[cs] + t4[cs], "R3 chip select length", cs_cnt,
        3 + t2[cs] + t3[cs] + t4[cs]);
    chk(st_first == 2 + t1[cs] + t2[cs], "R3 strobe start", st_first, 2 + t1[cs] + t2[cs]);
    chk(st_cnt == 1 + t3[cs], "R3 strobe length", st_cnt, 1 + t3[cs]);
    chk(other_cs == 0, "R2 R11 only target chip select", other_cs, 0);
    chk(wrong_st == 0, "R5 wrong strobe", wrong_st, 0);
    if (mux[cs]) chk(mux_bad == 0, "R9 address on data pins", mux_bad, 0);
    if (wr) chk(wd_bad == 0, nar[cs] ? "R7 narrow write data" :
                (byt ? "R12 byte flag on write" : "R5 write data"), wd_bad, 0);
    else begin
      chk(oe_bad == 0, "R9 pins released on read", oe_bad, 0);
      raw = (a ^ 16'h5A3C) + 16'(t3[cs]);
      if (nar[cs]) exp_rd = {8'h00, raw[7:0]};
      else if (byt) exp_rd = {8'h00, a[0] ? raw[15:8] : raw[7:0]};
      else exp_rd = raw;
      chk(rsp_rdata == exp_rd, nar[cs] ? "R7 narrow read" :
          (byt ? "R8 byte lane read" : "R10 R8 last strobe sample"), rsp_rdata, exp_rd);
    end
    @(negedge clk);
    chk(!rsp_done && &bus_cs_n, "R4 R11 done is one pulse, poke ignored", rsp_done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(&bus_cs_n && bus_rd_n && bus_wr_n && !bus_data_oe && !busy && !rsp_done && !rsp_err,
        "R1 reset state", bus_cs_n, 8'hFF);
    rst = 1'b0;
    @(negedge clk);
    chk(&bus_cs_n && !busy, "R1 idle after reset", busy, 0);
    for (int p = 0; p < 12; p++) begin
      @(negedge clk);
      load_cfg(p);
      for (int c = 0; c < NCS; c++) begin
        logic [15:0] a = 16'(p * 4099 + c * 257 + 6);
        access(c, 1'b0, 1'b0, a, 16'h0, 1'b1);
        access(c, 1'b0, 1'b1, a, 16'h0, 1'b0);
        access(c, 1'b0, 1'b1, a ^ 16'h1, 16'h0, 1'b0);
        access(c, 1'b1, 1'b0, a, 16'(a * 3 + 16'h1234), 1'b0);
        access(c, 1'b1, 1'b1, a ^ 16'h8, 16'(a ^ 16'hBEEF), 1'b0);
      end
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL R4 watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule